// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial bus target that holds a small bank of byte-wide configuration registers for a clock generator. A host writes to the bank with block transfers. The first two bytes after the address are a command code and a byte count. The target acknowledges both and discards their values. The data bytes that follow always fill the bank from register 0 upward, with no way to pick a starting register. A read returns a fixed byte count and then every register in order.

Both bus lines are sampled on the system clock through two-flop synchronizers. Start and stop conditions are found as SDA edges while SCL is high. SDA is open-drain: the block only asserts an output enable that pulls the line low. Register byte 3 is also decoded into named control fields for the clock logic next to the block. The bank leaves reset with a parameterised default value.

Top module: `i2c_cfg_target`

## Requirements
- R1: Only the address byte 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69 with the R/W bit in bit 0, is acknowledged. Any other address gets no acknowledge, and the target ignores the bus until the next start.
- R2: On a write, the first two bytes after the address (command code, byte count) are acknowledged and change no register.
- R3: The write data bytes are acknowledged and stored in ascending order, starting at register 0. Register i is carried on cfg_o[8*i+7:8*i].
- R4: A write that stops after k data bytes updates registers 0..k-1 only. All other registers keep their values.
- R5: A read sends the byte count 7 first, then registers 0 through 6, most significant bit first. Bytes requested after that read as 0xFF.
- R6: When the host does not acknowledge a read byte, the target stops driving SDA and does not drive it again before the next start.
- R7: Register 3 is decoded as follows: bit 7 gives spread_down_o, bits 6:4 give freq_code_o, bit 3 gives freq_by_reg_o (0 = pin select, 1 = register select), and bits 1:0 give mode_o (00 normal, 01 test, 10 spread on, 11 tristate).
- R8: Write data bytes beyond register 6 are acknowledged and discarded.
- R9: After reset, cfg_o equals the INIT parameter and SDA is released. Register contents change only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 8*NREG | Flattened register bank, register i at bits 8*i+7:8*i |
| spread_down_o | output | 1 | Spread type from register 3 bit 7 |
| freq_code_o | output | 3 | Frequency code from register 3 bits 6:4 |
| freq_by_reg_o | output | 1 | Frequency source select from register 3 bit 3 |
| mode_o | output | 2 | Operating mode from register 3 bits 1:0 |

## Verification
A wrong byte index shows up at once: a data byte lands in the wrong slice of cfg_o, or read-back returns a shifted sequence. Either is visible within the byte that follows the error. A wrong bit counter or a wrong phase moves the acknowledge slot, so a transfer loses its acknowledge within nine SCL periods. A target that leaves SDA enabled after a host NACK shows a low line on the next clocked bit. The bank is compared with a behavioural model on every system clock between transfers, so a register written out of turn cannot hide until a later read.

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter int              NREG     = 7,
  parameter logic [6:0]      DEV_ADDR = 7'h69,
  parameter logic [7:0]      RD_COUNT = 8'd7,
  parameter logic [8*NREG-1:0] INIT   = 56'h01_0F_00_00_FF_FF_FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [8*NREG-1:0] cfg_o,
  output logic              spread_down_o,
  output logic [2:0]        freq_code_o,
  output logic              freq_by_reg_o,
  output logic [1:0]        mode_o
);
  localparam int IW = $clog2(NREG + 3) + 1;
  localparam logic [IW-1:0] IDX_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [2:0] scl_q, sda_q;
  st_t st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx_byte;
  logic [IW-1:0] byte_idx;
  logic addr_ph, rd, nack;
  logic [8*NREG-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_h = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_h = sda_q[1];
  wire sda_p = sda_q[2];
  wire start_c = scl_h & scl_p & sda_p & ~sda_h;
  wire stop_c  = scl_h & scl_p & ~sda_p & sda_h;
  wire rise = scl_h & ~scl_p;
  wire fall = ~scl_h & scl_p;

  always_comb begin
    tx_byte = 8'hFF;
    if (byte_idx == '0) tx_byte = RD_COUNT;
    for (int i = 0; i < NREG; i++)
      if (byte_idx == IW'(i + 1)) tx_byte = cfg_q[8*i +: 8];
  end

  wire [IW-1:0] idx_inc = (byte_idx == IDX_MAX) ? byte_idx : byte_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      addr_ph  <= 1'b0;
      rd       <= 1'b0;
      nack     <= 1'b0;
      cfg_q    <= INIT;
    end else if (start_c) begin
      st       <= S_RX;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      byte_idx <= '0;
      addr_ph  <= 1'b1;
      rd       <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_h};
            bitcnt <= bitcnt + 1'b1;
          end else if (fall && bitcnt == 4'd8) begin
            if (addr_ph) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                rd      <= shreg[0];
                addr_ph <= 1'b0;
                st      <= S_RACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= S_RACK;
              for (int i = 0; i < NREG; i++)
                if (byte_idx == IW'(i + 2)) cfg_q[8*i +: 8] <= shreg;
              byte_idx <= idx_inc;
            end
          end
        S_RACK:
          if (fall) begin
            bitcnt <= '0;
            if (rd) begin
              st       <= S_TX;
              shreg    <= tx_byte;
              sda_oe   <= ~tx_byte[7];
              byte_idx <= idx_inc;
            end else begin
              st     <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        S_TX:
          if (fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= S_TACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        S_TACK:
          if (rise) begin
            nack <= sda_h;
          end else if (fall) begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              st       <= S_TX;
              shreg    <= tx_byte;
              sda_oe   <= ~tx_byte[7];
              byte_idx <= idx_inc;
            end
          end
        default: sda_oe <= 1'b0;
      endcase
    end

  assign cfg_o         = cfg_q;
  assign spread_down_o = cfg_q[31];
  assign freq_code_o   = cfg_q[30:28];
  assign freq_by_reg_o = cfg_q[27];
  assign mode_o        = cfg_q[25:24];

  p_pull_only_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_h);

  p_cfg_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> !scl_h);

  p_release_on_host_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TACK) |-> !sda_oe);

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start_c) |=> !sda_oe);

  p_reset_defaults_r9: assert property (@(posedge clk)
    !rst_n |=> (cfg_o == INIT && !sda_oe));
endmodule

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;
  localparam int NREG = 7;
  localparam logic [8*NREG-1:0] DEF = 56'h01_0F_00_00_FF_FF_FF;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, spread_down_o, freq_by_reg_o;
  logic [2:0] freq_code_o;
  logic [1:0] mode_o;
  logic [8*NREG-1:0] cfg_o;
  wire sda_bus = sda_m & ~sda_oe;

  int compared = 0, mismatched = 0;
  logic cmp_en = 1'b0;
  logic [7:0] m [NREG];

  always #4 clk = ~clk;

  i2c_cfg_target u_i2c_cfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_o(cfg_o), .spread_down_o(spread_down_o), .freq_code_o(freq_code_o),
    .freq_by_reg_o(freq_by_reg_o), .mode_o(mode_o));

  function automatic logic [8*NREG-1:0] model_vec();
    logic [8*NREG-1:0] v;
    for (int i = 0; i < NREG; i++) v[8*i +: 8] = m[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R3 bank vs model", 64'(cfg_o), 64'(model_vec()));
    chk("R7 decode", {57'd0, spread_down_o, freq_code_o, freq_by_reg_o, mode_o},
        {57'd0, m[3][7], m[3][6:4], m[3][3], m[3][1:0]});
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic bstop(); sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(2*Q); endtask
  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wq(Q); scl = 1; wq(Q); s = sda_bus; wq(Q); scl = 0; wq(Q);
  endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask
  task automatic rbyte(input logic host_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    bit_io(~host_ack, s);
  endtask

  task automatic do_write(input int n, input logic [7:0] base);
    logic a;
    cmp_en = 0;
    bstart();
    wbyte(8'hD2, a); chk("R1 write address ack", 64'(a), 64'd1);
    wbyte(8'h5A, a); chk("R2 command ack", 64'(a), 64'd1);
    wbyte(8'h33, a); chk("R2 count ack", 64'(a), 64'd1);
    chk("R2 no change", 64'(cfg_o), 64'(model_vec()));
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = base + 8'(k * 37);
      wbyte(d, a);
      if (k < NREG) begin
        m[k] = d; chk("R3 data ack", 64'(a), 64'd1);
      end else chk("R8 surplus ack", 64'(a), 64'd1);
      chk("R4 bank after byte", 64'(cfg_o), 64'(model_vec()));
    end
    bstop();
    cmp_en = 1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] v;
    for (int i = 0; i < NREG; i++) m[i] = DEF[8*i +: 8];
    wq(5);
    chk("R9 reset bank", 64'(cfg_o), 64'(DEF));
    chk("R9 reset sda", 64'(sda_oe), 64'd0);
    rst_n = 1; wq(5);
    cmp_en = 1;

    // R1: foreign address ignored, following bytes ignored
    cmp_en = 0;
    bstart();
    wbyte(8'hA0, a); chk("R1 foreign nack", 64'(a), 64'd0);
    wbyte(8'h00, a); chk("R1 ignored byte", 64'(a), 64'd0);
    wbyte(8'h12, a); chk("R1 ignored byte 2", 64'(a), 64'd0);
    bstop();
    chk("R1 bank unchanged", 64'(cfg_o), 64'(model_vec()));
    cmp_en = 1;

    do_write(7, 8'h11);          // R3 full bank
    do_write(2, 8'hC4);          // R4 partial
    do_write(9, 8'h6B);          // R8 surplus

    // R7: set byte 3 to down spread, code 5, register select, mode tristate
    do_write(4, 8'h00);
    cmp_en = 0; bstart();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a);
    for (int k = 0; k < 4; k++) begin
      wbyte(k == 3 ? 8'hDB : m[k], a);
      if (k == 3) m[3] = 8'hDB;
    end
    bstop(); cmp_en = 1;
    chk("R7 spread_down", 64'(spread_down_o), 64'd1);
    chk("R7 freq_code", 64'(freq_code_o), 64'd5);
    chk("R7 freq_by_reg", 64'(freq_by_reg_o), 64'd1);
    chk("R7 mode", 64'(mode_o), 64'd3);

    // R5: full read-back plus one extra byte
    bstart();
    wbyte(8'hD3, a); chk("R1 read address ack", 64'(a), 64'd1);
    rbyte(1'b1, v); chk("R5 byte count", 64'(v), 64'd7);
    for (int k = 0; k < NREG; k++) begin
      rbyte(1'b1, v); chk("R5 register byte", 64'(v), 64'(m[k]));
    end
    rbyte(1'b0, v); chk("R5 past end", 64'(v), 64'hFF);
    bstop();

    // R6: NACK after register 0 releases SDA
    bstart();
    wbyte(8'hD3, a);
    rbyte(1'b1, v); chk("R5 count again", 64'(v), 64'd7);
    rbyte(1'b0, v); chk("R5 reg0 again", 64'(v), 64'(m[0]));
    wq(10);
    chk("R6 released after nack", 64'(sda_oe), 64'd0);
    for (int k = 0; k < 3; k++) begin
      bit_io(1'b1, s); chk("R6 line stays high", 64'(s), 64'd1);
    end
    bstop();

    // R1: read after a NACK still works
    bstart();
    wbyte(8'hD3, a); chk("R1 readdress ack", 64'(a), 64'd1);
    rbyte(1'b0, v); chk("R5 count third", 64'(v), 64'd7);
    bstop();

    wq(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule